// File: doc/BRIEF.md
# Reverse-Subtract Execute Unit

This unit executes one 32-bit data-processing instruction word that has already been identified as a reverse subtract. It works out the second operand from the word, computes that operand minus the first source register, and checks the word's condition field against the stored flags. If the check passes, it drives a destination write port. The second operand can be a rotated 8-bit immediate, a register shifted by a constant, a register rotated right through carry, or a register shifted by the low byte of a third register. The difference is formed as the sum of the inverted first source, the second operand and a carry-in of one, so the carry flag reads 1 when no borrow occurred.

The unit sends the three register indices it needs to the register file through its index outputs. The register file returns the values in the same cycle, and the unit answers in that cycle too. The write port, the PC-destination outputs and the result are all combinational. The negative, zero, carry and overflow flags sit in a register. That register loads on the clock edge that ends a passing instruction with the set-flags bit (bit 20) at 1, unless the destination is register 15. When the destination is register 15, the result goes out on a separate PC port and no normal write takes place.

Top module: `rsb_exec`

## Requirements
- R1: When an accepted instruction passes its condition and bits 15:12 are not 15, wr_en_o is 1 in the same cycle, wr_idx_o equals bits 15:12, and wr_data_o equals (operand 2 minus rn_val_i) mod 2^32.
- R2: When such an instruction has bit 20 set, flags_o = {N,Z,C,V} (bit 3 down to bit 0) after the next rising edge. N is result bit 31. Z is 1 when the result is zero. C is 1 when operand 2 >= rn_val_i as unsigned values. V is 1 on signed overflow of the subtraction.
- R3: When bit 20 is 0, flags_o keeps its value.
- R4: When bits 27:25 are 001, operand 2 is bits 7:0 zero-extended and rotated right by twice the value of bits 11:8.
- R5: When bits 27:25 are 000 and bit 4 is 0, operand 2 is rm_val_i shifted by bits 11:7, with the shift kind in bits 6:5 (00 left, 01 logical right, 10 arithmetic right, 11 rotate right). An amount of 0 with kind 01 means a logical right shift by 32, giving 0. An amount of 0 with kind 10 means an arithmetic right shift by 32, giving the sign fill.
- R6: Kind 11 with a constant amount of 0 gives {C flag, rm_val_i[31:1]}.
- R7: When bits 27:25 are 000, bit 4 is 1 and bit 7 is 0, the amount is rs_lo_i (the low byte of the register indexed by bits 11:8). A left or logical right shift by 32 or more gives 0. An arithmetic right shift by 32 or more gives the sign fill. A rotate uses the amount modulo 32.
- R8: The condition in bits 31:28 is evaluated on the stored flags. 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always. 1111 never passes.
- R9: When the condition fails, wr_en_o and pc_wr_o are 0 and flags_o is unchanged.
- R10: When bits 15:12 are 15 and the condition passes, pc_wr_o is 1 with pc_data_o set to the result, wr_en_o is 0, and flags_o is unchanged whatever bit 20 holds.
- R11: A word whose bits 24:21 are not 0011, whose bits 27:25 are neither 000 nor 001, or that has bits 27:25 = 000 with both bit 4 and bit 7 set, or that arrives with valid_i at 0, produces no write and no flag change.
- R12: After reset, flags_o is 0000 and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| rn_idx_o | output | 4 | Index of the first source register (bits 19:16) |
| rm_idx_o | output | 4 | Index of the shifted register (bits 3:0) |
| rs_idx_o | output | 4 | Index of the shift-amount register (bits 11:8) |
| rn_val_i | input | 32 | Value of the first source register |
| rm_val_i | input | 32 | Value of the shifted register |
| rs_lo_i | input | 8 | Low byte of the shift-amount register |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | 4 | Destination register index |
| wr_data_o | output | 32 | Destination write data |
| pc_wr_o | output | 1 | Result targets the program counter |
| pc_data_o | output | 32 | Result for the program counter |
| flags_o | output | 4 | Stored {N,Z,C,V} |

## Verification
The write strobe, its index and data, and the PC outputs depend only on the current word and the stored flags. They are due in the same cycle that the word is driven. The new flags appear one rising edge later. The bench drives each word just after a falling edge and checks the combinational outputs one nanosecond later, before the next rising edge can change the flags that the condition and rotate-through-carry paths read. It then checks flags_o one nanosecond after that rising edge. The scoreboard tracks its own copy of the flags, so each expected item is built from the flags that the design held when the word was presented.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int INSTR_W = 32;
  localparam logic [3:0] OPC_RSB = 4'b0011;
  localparam logic [3:0] PC_IDX = 4'hF;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/rsb_op2.sv
module rsb_op2
  import rsb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         imm_form,
  input  logic [11:0]  field,
  input  logic [W-1:0] rm,
  input  logic [7:0]   rs_lo,
  input  logic         c_in,
  output logic [W-1:0] op2
);
  localparam int SHW = $clog2(W);
  localparam logic [7:0] WLIM = 8'(W);

  logic [W-1:0]   imm_w;
  logic [4:0]     rot2;
  logic [2*W-1:0] dbl_imm;
  logic [2*W-1:0] dbl_rm;
  logic           by_reg;
  logic [7:0]     amt;
  logic           amt_zero_imm;
  logic           big;
  shift_e         kind;
  logic [W-1:0]   shifted;
  logic           rrx_sel;

  always_comb begin
    imm_w   = {{(W-8){1'b0}}, field[7:0]};
    rot2    = {field[11:8], 1'b0};
    dbl_imm = {imm_w, imm_w} >> rot2;
  end

  always_comb begin
    by_reg       = field[4];
    amt          = by_reg ? rs_lo : {3'b000, field[11:7]};
    amt_zero_imm = !by_reg && (field[11:7] == 5'd0);
    big          = amt >= WLIM;
    kind         = shift_e'(field[6:5]);
    dbl_rm       = {rm, rm} >> amt[SHW-1:0];
    rrx_sel      = 1'b0;
    unique case (kind)
      SH_LSL: shifted = big ? '0 : (rm << amt[SHW-1:0]);
      SH_LSR: shifted = (big || amt_zero_imm) ? '0 : (rm >> amt[SHW-1:0]);
      SH_ASR: shifted = (big || amt_zero_imm) ? {W{rm[W-1]}}
                                              : W'($signed(rm) >>> amt[SHW-1:0]);
      default: begin
        if (amt_zero_imm) begin
          rrx_sel = 1'b1;
          shifted = {c_in, rm[W-1:1]};
        end else begin
          shifted = dbl_rm[W-1:0];
        end
      end
    endcase
    op2 = imm_form ? dbl_imm[W-1:0] : shifted;
  end

  always_comb begin
    if (!imm_form && rrx_sel) begin
      AST_RRX_CARRY_TOP: assert (op2[W-1] == c_in); // R6
    end
  end
endmodule

// File: rtl/rsb_cond.sv
module rsb_cond
  import rsb_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      fl,
  output logic       pass
);
  logic base;

  always_comb begin
    unique case (cond[3:1])
      3'b000: base = fl.z;
      3'b001: base = fl.c;
      3'b010: base = fl.n;
      3'b011: base = fl.v;
      3'b100: base = fl.c && !fl.z;
      3'b101: base = (fl.n == fl.v);
      3'b110: base = !fl.z && (fl.n == fl.v);
      default: base = !cond[0];
    endcase
    pass = (cond[3:1] == 3'b111) ? base : (base ^ cond[0]);
  end

  always_comb begin
    if (cond == 4'b1110) begin
      AST_ALWAYS_PASS: assert (pass); // R8
    end
    if (cond == 4'b1111) begin
      AST_NEVER_PASS: assert (!pass); // R8
    end
  end
endmodule

// File: rtl/rsb_alu.sv
module rsb_alu
  import rsb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] res,
  output nzcv_t        fl
);
  logic [W:0] sum;

  always_comb begin
    sum  = {1'b0, ~src_a} + {1'b0, src_b} + {{W{1'b0}}, 1'b1};
    res  = sum[W-1:0];
    fl.n = res[W-1];
    fl.z = (res == '0);
    fl.c = sum[W];
    fl.v = (~src_a[W-1] == src_b[W-1]) && (res[W-1] != src_b[W-1]);
  end
endmodule

// File: rtl/rsb_exec.sv
module rsb_exec
  import rsb_pkg::*;
#(
  parameter int W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [31:0]  instr_i,
  output logic [3:0]   rn_idx_o,
  output logic [3:0]   rm_idx_o,
  output logic [3:0]   rs_idx_o,
  input  logic [W-1:0] rn_val_i,
  input  logic [W-1:0] rm_val_i,
  input  logic [7:0]   rs_lo_i,
  output logic         wr_en_o,
  output logic [3:0]   wr_idx_o,
  output logic [W-1:0] wr_data_o,
  output logic         pc_wr_o,
  output logic [W-1:0] pc_data_o,
  output logic [3:0]   flags_o
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  nzcv_t        flags_q;
  nzcv_t        flags_d;
  nzcv_t        alu_fl;
  logic [W-1:0] op2;
  logic [W-1:0] res;
  logic         cond_pass;
  logic         legal;
  logic         go;
  logic         pc_dest;
  logic         flag_en;

  rsb_op2 #(.W(W)) u_op2 (
    .imm_form (instr_i[27:25] == 3'b001),
    .field    (instr_i[11:0]),
    .rm       (rm_val_i),
    .rs_lo    (rs_lo_i),
    .c_in     (flags_q.c),
    .op2      (op2)
  );

  rsb_cond u_cond (
    .cond (instr_i[31:28]),
    .fl   (flags_q),
    .pass (cond_pass)
  );

  rsb_alu #(.W(W)) u_alu (
    .src_a (rn_val_i),
    .src_b (op2),
    .res   (res),
    .fl    (alu_fl)
  );

  always_comb begin
    legal   = (instr_i[24:21] == OPC_RSB) &&
              ((instr_i[27:25] == 3'b001) ||
               ((instr_i[27:25] == 3'b000) && !(instr_i[4] && instr_i[7])));
    go      = valid_i && legal && cond_pass;
    pc_dest = (instr_i[15:12] == PC_IDX);
    flag_en = go && instr_i[20] && !pc_dest;
    flags_d = flag_en ? alu_fl : flags_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_q <= '0;
    else             flags_q <= flags_d;
  end

  assign rn_idx_o  = instr_i[19:16];
  assign rm_idx_o  = instr_i[3:0];
  assign rs_idx_o  = instr_i[11:8];
  assign wr_en_o   = go && !pc_dest;
  assign wr_idx_o  = instr_i[15:12];
  assign wr_data_o = res;
  assign pc_wr_o   = go && pc_dest;
  assign pc_data_o = res;
  assign flags_o   = flags_q;

  AST_DIFF_SUM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en_o |-> ((wr_data_o + rn_val_i) == op2)); // R1
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_o && instr_i[20]) |=> (flags_o == $past(alu_fl))); // R2
  AST_NO_S_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_i[20] |=> $stable(flags_o)); // R3
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cond_pass |-> (!wr_en_o && !pc_wr_o)); // R9
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cond_pass |=> $stable(flags_o)); // R9
  AST_PC_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_wr_o |-> !wr_en_o); // R10
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_wr_o |=> $stable(flags_o)); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!valid_i || !legal) |=> (!$past(wr_en_o) && $stable(flags_o))); // R11
endmodule

// File: tb/sim_rsb_exec.sv
`timescale 1ns/1ps
module sim_rsb_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rn_val_i = '0;
  logic [31:0] rm_val_i = '0;
  logic [7:0]  rs_lo_i = '0;
  logic [3:0]  rn_idx_o, rm_idx_o, rs_idx_o, wr_idx_o, flags_o;
  logic        wr_en_o, pc_wr_o;
  logic [31:0] wr_data_o, pc_data_o;

  always #2.5 clk = ~clk;

  rsb_exec u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .rn_idx_o(rn_idx_o), .rm_idx_o(rm_idx_o), .rs_idx_o(rs_idx_o),
    .rn_val_i(rn_val_i), .rm_val_i(rm_val_i), .rs_lo_i(rs_lo_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .pc_wr_o(pc_wr_o), .pc_data_o(pc_data_o), .flags_o(flags_o)
  );

  typedef struct {
    string       tag;
    logic        wr;
    logic        pc;
    logic [3:0]  idx;
    logic [31:0] data;
    logic [3:0]  fl;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [3:0]  mflags = 4'h0;
  logic        done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_imm(logic [3:0] c, logic s, logic [3:0] rn,
                                          logic [3:0] rd, logic [3:0] rot, logic [7:0] i8);
    return {c, 3'b001, 4'b0011, s, rn, rd, rot, i8};
  endfunction

  function automatic logic [31:0] enc_si(logic [3:0] c, logic s, logic [3:0] rn,
                                         logic [3:0] rd, logic [4:0] a, logic [1:0] k, logic [3:0] rm);
    return {c, 3'b000, 4'b0011, s, rn, rd, a, k, 1'b0, rm};
  endfunction

  function automatic logic [31:0] enc_sr(logic [3:0] c, logic s, logic [3:0] rn,
                                         logic [3:0] rd, logic [3:0] rs, logic [1:0] k, logic [3:0] rm);
    return {c, 3'b000, 4'b0011, s, rn, rd, rs, 1'b0, k, 1'b1, rm};
  endfunction

  function automatic logic cond_ok(logic [3:0] c, logic [3:0] f);
    logic n = f[3], z = f[2], cc = f[1], v = f[0];
    case (c)
      4'h0: return z;          4'h1: return !z;
      4'h2: return cc;         4'h3: return !cc;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return cc && !z;   4'h9: return !cc || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] shift_model(logic [31:0] x, int a, logic [1:0] k, logic cin, logic rrx);
    logic [63:0] d;
    if (rrx) return {cin, x[31:1]};
    case (k)
      2'b00: return (a >= 32) ? 32'h0 : x << a;
      2'b01: return (a >= 32) ? 32'h0 : x >> a;
      2'b10: return (a >= 32) ? {32{x[31]}} : 32'($signed(x) >>> a);
      default: begin
        d = {x, x} >> (a % 32);
        return d[31:0];
      end
    endcase
  endfunction

  task automatic send(string tag, logic [31:0] w, logic [31:0] rn, logic [31:0] rm,
                      logic [7:0] rs, logic vld = 1'b1);
    exp_t        e;
    logic [31:0] o2;
    logic [63:0] d;
    logic [32:0] sd;
    logic        legal, go;
    int          a;
    @(negedge clk);
    valid_i = vld; instr_i = w; rn_val_i = rn; rm_val_i = rm; rs_lo_i = rs;
    if (w[27:25] == 3'b001) begin
      d  = {32'h0, 24'h0, w[7:0]};
      d  = {d[31:0], d[31:0]} >> (2 * w[11:8]);
      o2 = d[31:0];
    end else if (w[4]) begin
      o2 = shift_model(rm, int'(rs), w[6:5], mflags[1], 1'b0);
    end else begin
      a = int'(w[11:7]);
      if (a == 0 && (w[6:5] == 2'b01 || w[6:5] == 2'b10)) a = 32;
      o2 = shift_model(rm, a, w[6:5], mflags[1], (a == 0 && w[6:5] == 2'b11));
    end
    legal = (w[24:21] == 4'b0011) &&
            (w[27:25] == 3'b001 || (w[27:25] == 3'b000 && !(w[4] && w[7])));
    go    = vld && legal && cond_ok(w[31:28], mflags);
    e.tag  = tag;
    e.data = o2 - rn;
    e.idx  = w[15:12];
    e.wr   = go && (w[15:12] != 4'hF);
    e.pc   = go && (w[15:12] == 4'hF);
    if (e.wr && w[20]) begin
      sd = {o2[31], o2} - {rn[31], rn};
      mflags = {e.data[31], e.data == 32'h0, o2 >= rn, sd[32] != sd[31]};
    end
    e.fl = mflags;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk({e.tag, " wr_en"}, {31'h0, wr_en_o}, {31'h0, e.wr});
        chk({e.tag, " pc_wr"}, {31'h0, pc_wr_o}, {31'h0, e.pc});
        if (e.wr) begin
          chk({e.tag, " idx"}, {28'h0, wr_idx_o}, {28'h0, e.idx});
          chk({e.tag, " data"}, wr_data_o, e.data);
        end
        if (e.pc) chk({e.tag, " pc_data"}, pc_data_o, e.data);
        @(posedge clk);
        #1;
        chk({e.tag, " flags"}, {28'h0, flags_o}, {28'h0, e.fl});
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    #12 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset flags", {28'h0, flags_o}, 32'h0);
    chk("R12 reset write", {31'h0, wr_en_o}, 32'h0);
    // immediates
    send("R4 R1 R2 imm small", enc_imm(4'hE, 1, 4'd1, 4'd2, 4'd0, 8'h10), 32'd5, 0, 0);
    send("R4 rot8", enc_imm(4'hE, 1, 4'd1, 4'd3, 4'd4, 8'hFF), 32'd1, 0, 0);
    send("R4 rot2", enc_imm(4'hE, 0, 4'd1, 4'd3, 4'd1, 8'h03), 32'd0, 0, 0);
    send("R2 borrow", enc_imm(4'hE, 1, 4'd1, 4'd4, 4'd0, 8'h02), 32'd9, 0, 0);
    send("R2 zero", enc_imm(4'hE, 1, 4'd1, 4'd4, 4'd0, 8'h07), 32'd7, 0, 0);
    // constant shifts
    send("R2 overflow", enc_si(4'hE, 1, 4'd1, 4'd5, 5'd0, 2'b00, 4'd6), 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0);
    send("R5 lsl4", enc_si(4'hE, 1, 4'd1, 4'd5, 5'd4, 2'b00, 4'd6), 32'd3, 32'h1234_5678, 0);
    send("R5 lsr32", enc_si(4'hE, 0, 4'd1, 4'd5, 5'd0, 2'b01, 4'd6), 32'd3, 32'hFFFF_0000, 0);
    send("R5 asr32", enc_si(4'hE, 0, 4'd1, 4'd5, 5'd0, 2'b10, 4'd6), 32'd0, 32'h8000_0001, 0);
    send("R5 asr3", enc_si(4'hE, 0, 4'd1, 4'd5, 5'd3, 2'b10, 4'd6), 32'd1, 32'hF000_0000, 0);
    send("R5 ror8", enc_si(4'hE, 1, 4'd1, 4'd5, 5'd8, 2'b11, 4'd6), 32'd0, 32'h1122_3344, 0);
    // set C then RRX, clear C then RRX
    send("R2 setc", enc_imm(4'hE, 1, 4'd1, 4'd7, 4'd0, 8'h05), 32'd1, 0, 0);
    send("R6 rrx c1", enc_si(4'hE, 0, 4'd1, 4'd7, 5'd0, 2'b11, 4'd6), 32'd0, 32'h0000_0003, 0);
    send("R2 clrc", enc_imm(4'hE, 1, 4'd1, 4'd7, 4'd0, 8'h01), 32'd5, 0, 0);
    send("R6 rrx c0", enc_si(4'hE, 1, 4'd1, 4'd7, 5'd0, 2'b11, 4'd6), 32'd0, 32'hFFFF_FFFF, 0);
    // register shifts
    send("R7 lsl33", enc_sr(4'hE, 0, 4'd1, 4'd8, 4'd9, 2'b00, 4'd6), 32'd2, 32'hFFFF_FFFF, 8'd33);
    send("R7 lsl32", enc_sr(4'hE, 0, 4'd1, 4'd8, 4'd9, 2'b00, 4'd6), 32'd2, 32'hFFFF_FFFF, 8'd32);
    send("R7 lsr40", enc_sr(4'hE, 0, 4'd1, 4'd8, 4'd9, 2'b01, 4'd6), 32'd0, 32'hFFFF_FFFF, 8'd40);
    send("R7 asr200", enc_sr(4'hE, 0, 4'd1, 4'd8, 4'd9, 2'b10, 4'd6), 32'd0, 32'h8000_0000, 8'd200);
    send("R7 ror36", enc_sr(4'hE, 0, 4'd1, 4'd8, 4'd9, 2'b11, 4'd6), 32'd0, 32'h0000_00F1, 8'd36);
    send("R7 lsl0", enc_sr(4'hE, 0, 4'd1, 4'd8, 4'd9, 2'b00, 4'd6), 32'd1, 32'h0000_0100, 8'd0);
    send("R7 lsr5", enc_sr(4'hE, 1, 4'd1, 4'd8, 4'd9, 2'b01, 4'd6), 32'd1, 32'h0000_0100, 8'd5);
    // S clear keeps flags
    send("R3 no S", enc_imm(4'hE, 0, 4'd1, 4'd2, 4'd0, 8'h00), 32'd1, 0, 0);
    // conditions: flags now known from the model
    send("R2 make zc", enc_imm(4'hE, 1, 4'd1, 4'd2, 4'd0, 8'h04), 32'd4, 0, 0);
    send("R8 eq pass", enc_imm(4'h0, 1, 4'd1, 4'd2, 4'd0, 8'h09), 32'd2, 0, 0);
    send("R9 eq fail", enc_imm(4'h0, 1, 4'd1, 4'd2, 4'd0, 8'h09), 32'd2, 0, 0);
    send("R8 ne pass", enc_imm(4'h1, 1, 4'd1, 4'd2, 4'd0, 8'h01), 32'd2, 0, 0);
    send("R8 mi pass", enc_imm(4'h4, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd2, 0, 0);
    send("R9 cs fail", enc_imm(4'h2, 1, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 lt check", enc_imm(4'hB, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 ge check", enc_imm(4'hA, 1, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 hi check", enc_imm(4'h8, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 ls check", enc_imm(4'h9, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 gt check", enc_imm(4'hC, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 le check", enc_imm(4'hD, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 vc check", enc_imm(4'h7, 0, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    send("R8 nv never", enc_imm(4'hF, 1, 4'd1, 4'd2, 4'd0, 8'h01), 32'd0, 0, 0);
    // PC destination
    send("R10 pc dest S", enc_imm(4'hE, 1, 4'd1, 4'hF, 4'd0, 8'h40), 32'h10, 0, 0);
    send("R10 pc dest", enc_si(4'hE, 0, 4'd1, 4'hF, 5'd2, 2'b00, 4'd6), 32'h4, 32'h100, 0);
    // unrecognised layouts
    send("R11 opcode", {4'hE, 3'b001, 4'b0100, 1'b1, 4'd1, 4'd2, 12'h0FF}, 32'd1, 0, 0);
    send("R11 class", {4'hE, 3'b010, 4'b0011, 1'b1, 4'd1, 4'd2, 12'h0FF}, 32'd1, 0, 0);
    send("R11 b4b7", {4'hE, 3'b000, 4'b0011, 1'b1, 4'd1, 4'd2, 12'h096}, 32'd1, 32'd5, 8'd1);
    send("R11 no valid", enc_imm(4'hE, 1, 4'd1, 4'd2, 4'd0, 8'h00), 32'd1, 0, 0, 1'b0);
    send("R1 after", enc_imm(4'hE, 1, 4'd1, 4'd2, 4'd0, 8'h80), 32'd1, 0, 0);
    @(negedge clk);
    valid_i = 1'b0;
    wait (sb.size() == 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule